// File: doc/BRIEF.md
# Adaptive Cluster Reconfiguration Multiplexer

This block sits between a set of stream-register-file banks and an equal number of compute clusters. It lets the number of working clusters track the data parallelism of the current workload. With every cluster on, each bank drives the cluster of the same index. In the half and quarter modes, fewer clusters stay on, and the words of all banks are steered into them over two or four cycles. The remaining clusters get a power-gate request, so their static and dynamic power can be removed. No data has to be moved through memory first.

The bank side holds a word set steady while it is being funnelled. The block pulses a step output in the cycle that takes the last slice of the set. A mode request is applied only in a cycle flagged as a stream boundary. That cycle carries no data, and the gate requests change at its closing edge. A cluster that is being switched back on therefore sees its gate request drop one cycle before its first word arrives. Mode changes are expected to be rare, on the order of once per thousand cycles.

Top module: `clusterReconfigMux`

## Requirements
- R1: While `rstN` is low, and at the first edge after it is released, every `gateOff` bit is 1, `clusterValid` is all zero, `clusterData` is all zero and `bankStep` is 0. After reset the block is in the all-off mode.
- R2: `modeReq` is sampled only in a cycle with `streamEdge` high. In any other cycle its value has no effect on any output.
- R3: Mode code 0 (full). At the edge after an input cycle, cluster c carries the word of bank c with its valid bit set. `bankStep` is 1 in every data cycle.
- R4: Mode code 1 (half). Clusters 0 and 1 are active. In phase 0 they receive banks 0 and 1; in phase 1 they receive banks 2 and 3. Phases alternate, and `bankStep` is 1 only in phase 1.
- R5: Mode code 2 (quarter). Only cluster 0 is active. It receives banks 0, 1, 2 and 3 in phases 0 to 3, in that order. `bankStep` is 1 only in phase 3.
- R6: `gateOff[c]` is 1 exactly when cluster c is unused in the active mode: clusters 2 and 3 in half mode, clusters 1 to 3 in quarter mode, all clusters in off mode. A gated cluster has valid 0 and data 0.
- R7: A cycle with `streamEdge` high transfers no data. At its closing edge the new gate pattern appears and all cluster outputs are zero. The first data in the new mode appears one edge later, one cycle after a re-enabled cluster's gate drops.
- R8: Mode code 3 (all off). All `gateOff` bits are 1, all cluster outputs are zero, and `bankStep` stays 0.
- R9: Each stream boundary restarts the phase at 0, even when the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| streamEdge | input | 1 | Marks a stream-boundary cycle in which `modeReq` is applied |
| modeReq | input | 2 | Requested mode: 0 full, 1 half, 2 quarter, 3 all off |
| bankData | input | NUM_LANES*DATA_W | Bank words; bank b occupies bits [b*DATA_W +: DATA_W] |
| clusterData | output | NUM_LANES*DATA_W | Registered cluster words, same lane packing |
| clusterValid | output | NUM_LANES | Per-cluster valid, registered |
| gateOff | output | NUM_LANES | Per-cluster power-gate request, 1 = gated |
| bankStep | output | 1 | Current bank word set is fully taken this cycle |

## Verification
The bench builds the block with its defaults: four lanes and 16-bit words. At this size every steering pattern can be compared word by word, with each bank's index encoded in its word. The two- and four-phase sequences are walked across their wrap. This also reaches the phase restart at a boundary that lands mid-sequence, and the exact cycle offset between a gate dropping and its cluster's first word.

// File: rtl/clusterMuxPkg.sv
package clusterMuxPkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_HALF    = 2'd1,
    MODE_QUARTER = 2'd2,
    MODE_OFF     = 2'd3
  } clusterMode_t;

  // Widest reduction is 4:1, so the phase counter needs two bits.
  localparam int PHASE_W = 2;

  typedef struct packed {
    clusterMode_t         mode;
    logic [PHASE_W-1:0]   phase;
    logic                 xfer;
  } steerStrobes_t;

  function automatic int activeLanes(input clusterMode_t m, input int lanes);
    case (m)
      MODE_FULL:    return lanes;
      MODE_HALF:    return lanes / 2;
      MODE_QUARTER: return lanes / 4;
      default:      return 0;
    endcase
  endfunction

  function automatic int ratioOf(input clusterMode_t m);
    case (m)
      MODE_HALF:    return 2;
      MODE_QUARTER: return 4;
      default:      return 1;
    endcase
  endfunction

endpackage

// File: rtl/clusterSteerCtrl.sv
module clusterSteerCtrl
  import clusterMuxPkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 streamEdge,
  input  logic [1:0]           modeReq,
  output steerStrobes_t        strobes,
  output logic [NUM_LANES-1:0] gateOff,
  output logic                 bankStep
);

  clusterMode_t         modeReg;
  logic [PHASE_W-1:0]   phaseReg;
  logic [PHASE_W-1:0]   phaseLast;
  logic [NUM_LANES-1:0] gateNext;
  clusterMode_t         modeNext;

  assign modeNext  = clusterMode_t'(modeReq);
  assign phaseLast = PHASE_W'(ratioOf(modeReg) - 1);

  always_comb begin
    for (int c = 0; c < NUM_LANES; c++) begin
      gateNext[c] = (c >= activeLanes(modeNext, NUM_LANES));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_OFF;
      phaseReg <= '0;
      gateOff  <= '1;
    end else if (streamEdge) begin
      modeReg  <= modeNext;
      phaseReg <= '0;
      gateOff  <= gateNext;
    end else if (modeReg != MODE_OFF) begin
      phaseReg <= (phaseReg == phaseLast) ? '0 : phaseReg + PHASE_W'(1);
    end
  end

  assign strobes.mode  = modeReg;
  assign strobes.phase = phaseReg;
  assign strobes.xfer  = !streamEdge && (modeReg != MODE_OFF);
  assign bankStep      = strobes.xfer && (phaseReg == phaseLast);

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !streamEdge |=> $stable(gateOff));

  // R5
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseReg <= phaseLast);

  // R8
  off_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_OFF) |-> !bankStep);

  // R9
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    streamEdge |=> (phaseReg == '0));

endmodule

// File: rtl/clusterSteerPath.sv
module clusterSteerPath
  import clusterMuxPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  steerStrobes_t                 strobes,
  input  logic [NUM_LANES*DATA_W-1:0]   bankData,
  output logic [NUM_LANES*DATA_W-1:0]   clusterData,
  output logic [NUM_LANES-1:0]          clusterValid
);

  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [DATA_W-1:0] bankWord [NUM_LANES];
  int                actCount;

  assign actCount = activeLanes(strobes.mode, NUM_LANES);

  for (genvar b = 0; b < NUM_LANES; b++) begin : g_unpack
    assign bankWord[b] = bankData[b*DATA_W +: DATA_W];
  end

  for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
    logic [LANE_W-1:0] srcIdx;
    logic              laneOn;

    // Active cluster c takes bank c + activeCount * phase.
    assign srcIdx = LANE_W'(c + actCount * int'(strobes.phase));
    assign laneOn = strobes.xfer && (c < actCount);

    always_ff @(posedge clk) begin
      if (!rstN || !laneOn) begin
        clusterData[c*DATA_W +: DATA_W] <= '0;
        clusterValid[c]                 <= 1'b0;
      end else begin
        clusterData[c*DATA_W +: DATA_W] <= bankWord[srcIdx];
        clusterValid[c]                 <= 1'b1;
      end
    end
  end

  // R7
  idle_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.xfer |=> (clusterValid == '0));

  // R5
  quarter_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.mode == MODE_QUARTER) |=> ($countones(clusterValid) <= 1));

endmodule

// File: rtl/clusterReconfigMux.sv
module clusterReconfigMux
  import clusterMuxPkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          streamEdge,
  input  logic [1:0]                    modeReq,
  input  logic [NUM_LANES*DATA_W-1:0]   bankData,
  output logic [NUM_LANES*DATA_W-1:0]   clusterData,
  output logic [NUM_LANES-1:0]          clusterValid,
  output logic [NUM_LANES-1:0]          gateOff,
  output logic                          bankStep
);

  steerStrobes_t strobes;

  clusterSteerCtrl #(.NUM_LANES(NUM_LANES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .streamEdge (streamEdge),
    .modeReq    (modeReq),
    .strobes    (strobes),
    .gateOff    (gateOff),
    .bankStep   (bankStep)
  );

  clusterSteerPath #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .bankData     (bankData),
    .clusterData  (clusterData),
    .clusterValid (clusterValid)
  );

  // R6
  gated_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clusterValid & gateOff) == '0);

  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&gateOff) |-> (clusterData == '0));

endmodule

// File: tb/test_clusterReconfigMux.sv
module test_clusterReconfigMux;

  localparam int NL = 4;
  localparam int DW = 16;
  localparam int NV = 19;

  logic              clk = 1'b0;
  logic              rstN;
  logic              streamEdge;
  logic [1:0]        modeReq;
  logic [NL*DW-1:0]  bankData;
  logic [NL*DW-1:0]  clusterData;
  logic [NL-1:0]     clusterValid;
  logic [NL-1:0]     gateOff;
  logic              bankStep;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clusterReconfigMux #(.NUM_LANES(NL), .DATA_W(DW)) i_clusterReconfigMux (
    .clk(clk), .rstN(rstN), .streamEdge(streamEdge), .modeReq(modeReq),
    .bankData(bankData), .clusterData(clusterData), .clusterValid(clusterValid),
    .gateOff(gateOff), .bankStep(bankStep)
  );

  // {req[4], edge[1], mode[2], seed[8], step[1], gate[4], sel0..sel3[3 each]}; sel 7 = idle lane
  localparam logic [31:0] VEC [NV] = '{
    {4'd7, 1'b1, 2'd0, 8'h01, 1'b0, 4'b0000, 3'd7, 3'd7, 3'd7, 3'd7}, // R7 off -> full
    {4'd3, 1'b0, 2'd0, 8'h02, 1'b1, 4'b0000, 3'd0, 3'd1, 3'd2, 3'd3}, // R3
    {4'd2, 1'b0, 2'd2, 8'h03, 1'b1, 4'b0000, 3'd0, 3'd1, 3'd2, 3'd3}, // R2 request ignored
    {4'd7, 1'b1, 2'd1, 8'h04, 1'b0, 4'b1100, 3'd7, 3'd7, 3'd7, 3'd7}, // R7 -> half
    {4'd4, 1'b0, 2'd1, 8'h05, 1'b0, 4'b1100, 3'd0, 3'd1, 3'd7, 3'd7}, // R4 phase 0
    {4'd4, 1'b0, 2'd1, 8'h06, 1'b1, 4'b1100, 3'd2, 3'd3, 3'd7, 3'd7}, // R4 phase 1
    {4'd6, 1'b0, 2'd1, 8'h07, 1'b0, 4'b1100, 3'd0, 3'd1, 3'd7, 3'd7}, // R6 gated lanes idle
    {4'd7, 1'b1, 2'd2, 8'h08, 1'b0, 4'b1110, 3'd7, 3'd7, 3'd7, 3'd7}, // R7 -> quarter
    {4'd5, 1'b0, 2'd2, 8'h09, 1'b0, 4'b1110, 3'd0, 3'd7, 3'd7, 3'd7}, // R5
    {4'd5, 1'b0, 2'd2, 8'h0A, 1'b0, 4'b1110, 3'd1, 3'd7, 3'd7, 3'd7}, // R5
    {4'd5, 1'b0, 2'd2, 8'h0B, 1'b0, 4'b1110, 3'd2, 3'd7, 3'd7, 3'd7}, // R5
    {4'd5, 1'b0, 2'd2, 8'h0C, 1'b1, 4'b1110, 3'd3, 3'd7, 3'd7, 3'd7}, // R5 last slice
    {4'd5, 1'b0, 2'd2, 8'h0D, 1'b0, 4'b1110, 3'd0, 3'd7, 3'd7, 3'd7}, // R5 wrap
    {4'd9, 1'b1, 2'd2, 8'h0E, 1'b0, 4'b1110, 3'd7, 3'd7, 3'd7, 3'd7}, // R9 same-mode boundary
    {4'd9, 1'b0, 2'd2, 8'h0F, 1'b0, 4'b1110, 3'd0, 3'd7, 3'd7, 3'd7}, // R9 phase restarted
    {4'd8, 1'b1, 2'd3, 8'h10, 1'b0, 4'b1111, 3'd7, 3'd7, 3'd7, 3'd7}, // R8 -> off
    {4'd8, 1'b0, 2'd0, 8'h11, 1'b0, 4'b1111, 3'd7, 3'd7, 3'd7, 3'd7}, // R8 stays off
    {4'd7, 1'b1, 2'd0, 8'h12, 1'b0, 4'b0000, 3'd7, 3'd7, 3'd7, 3'd7}, // R7 gate drops, no data yet
    {4'd3, 1'b0, 2'd0, 8'h13, 1'b1, 4'b0000, 3'd0, 3'd1, 3'd2, 3'd3}  // R3 data one cycle later
  };

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic se, input logic [1:0] mode, input logic [7:0] seed);
    @(negedge clk);
    streamEdge = se;
    modeReq    = mode;
    for (int b = 0; b < NL; b++) bankData[b*DW +: DW] = {seed, 8'(b)};
  endtask

  task automatic checkIdle(input string tag);
    chk(tag, "gateOff", 64'(gateOff), 64'hF);
    chk(tag, "clusterValid", 64'(clusterValid), 64'h0);
    chk(tag, "clusterData", clusterData, 64'h0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; streamEdge = 1'b0; modeReq = 2'd0; bankData = '0;
    repeat (3) @(posedge clk);
    #1;
    checkIdle("R1");
    chk("R1", "bankStep", 64'(bankStep), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: after release, still off with no boundary
    drive(1'b0, 2'd0, 8'hEE);
    #1 chk("R1", "bankStep", 64'(bankStep), 64'h0);
    @(posedge clk); #1;
    checkIdle("R1");

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[31:28]);
      drive(v[27], v[26:25], v[24:17]);
      #1 chk(tag, "bankStep", 64'(bankStep), 64'(v[16]));
      @(posedge clk); #1;
      chk(tag, "gateOff", 64'(gateOff), 64'(v[15:12]));
      for (int c = 0; c < NL; c++) begin
        logic [2:0] sel;
        logic [DW-1:0] expData;
        sel = v[11 - 3*c -: 3];
        expData = (sel == 3'd7) ? '0 : {v[24:17], 8'(sel)};
        chk(tag, $sformatf("cluster%0d data", c), 64'(clusterData[c*DW +: DW]), 64'(expData));
        chk(tag, $sformatf("cluster%0d valid", c), 64'(clusterValid[c]), 64'(sel != 3'd7));
      end
    end

    // R1: reset in the middle of a quarter-mode stream
    drive(1'b1, 2'd2, 8'h20);
    drive(1'b0, 2'd2, 8'h21);
    @(negedge clk);
    rstN = 1'b0;
    streamEdge = 1'b0;
    #1 chk("R1", "bankStep in reset", 64'(bankStep), 64'h0);
    @(posedge clk); #1;
    checkIdle("R1");
    @(negedge clk);
    rstN = 1'b1;
    // R2: full-mode request without a boundary keeps everything gated
    drive(1'b0, 2'd0, 8'h22);
    #1 chk("R2", "bankStep", 64'(bankStep), 64'h0);
    @(posedge clk); #1;
    checkIdle("R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule